// File: doc/BRIEF.md
# Command Event Counter and Interrupt Status

This block keeps, for one DMA channel, a running tally of command events raised by the channel hardware and the portion of that tally that software has already acknowledged. Each cycle on which the event input is high, a wrapping done counter advances. Software acknowledges by writing back, into a separate processed field, the done value it last read. The distance between the two counters, taken modulo the counter range, is the number of events still waiting for service.

An interrupt-active flag is raised by events whose class is enabled in a small configuration word. The interrupt output either follows a level rule (flag set, or waiting events with some enable on) or gives a one-cycle pulse per enabled event. Both words sit behind a plain single-cycle register port. Reads are combinational. Hardware keeps counting while software reads and acknowledges, so a read taken after the acknowledge shows any event that landed in between.

Top module: `cmdcnt_status`

## Requirements
- R1: While and after reset, before any write or event, both words read 0 and `irq` is low.
- R2: With `reg_addr`=1 the counter word is read: done count in bits 5:0, interrupt-active in bit 8, processed count in bits 21:16, all other bits 0.
- R3: With `reg_addr`=0 the configuration word is read and written: bit 31 enables list-load events, bit 29 enables command-done events, bit 28 selects level mode (1) or pulse mode (0); all other bits are ignored on write and read as 0.
- R4: Each cycle with `evt_valid` high adds one to the done count, which wraps from 63 to 0; without an event it holds.
- R5: A write to the counter word loads the processed count from bits 21:16 and the interrupt-active flag from bit 8; the done field of the write (bits 5:0) has no effect.
- R6: When an event and a counter-word write fall in the same cycle, the done count still advances, and an enabled event leaves interrupt-active set whatever the write carried.
- R7: An event with `evt_list`=1 sets interrupt-active only if bit 31 is set; an event with `evt_list`=0 only if bit 29 is set; otherwise the flag is left unchanged.
- R8: In level mode `irq` is high when interrupt-active is set, or when (done − processed) mod 64 is nonzero and bit 31 or bit 29 is set; otherwise low.
- R9: In pulse mode `irq` is high for exactly the one cycle after each enabled event and low otherwise.
- R10: Register updates become visible on `reg_rdata` and `irq` in the cycle after the clock edge that takes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One command event this cycle |
| evt_list | input | 1 | Event class: 1 list loaded, 0 command done |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 configuration, 1 counters |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| irq | output | 1 | Interrupt request |

## Verification
Events are sent with every enable off, with only one class enabled and with both, which separates counting from flag setting and checks that each class listens to its own enable bit. A long burst of more than 64 events forces the wrap, after which a correct acknowledge must bring the level output low while a stale acknowledge must keep it high through the nonzero gap. Writes that carry junk in the done field and writes that coincide with events show that software cannot move the done count and cannot lose an increment. The same event patterns are repeated in pulse mode to tell the one-cycle pulse apart from the level rule.

// File: rtl/cmdcnt_pkg.sv
package cmdcnt_pkg;
  // Counter-word field positions (software decodes these).
  localparam int unsigned DONE_LSB   = 0;
  localparam int unsigned ACTIVE_BIT = 8;
  localparam int unsigned PROC_LSB   = 16;
  // Configuration-word bit positions.
  localparam int unsigned LIST_EN_BIT = 31;
  localparam int unsigned CMD_EN_BIT  = 29;
  localparam int unsigned LEVEL_BIT   = 28;

  typedef struct packed {
    logic list_en;
    logic cmd_en;
    logic level;
  } cfg_t;
endpackage

// File: rtl/cmdcnt_cfg_reg.sv
module cmdcnt_cfg_reg
  import cmdcnt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg
);
  cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q.list_en <= wdata[LIST_EN_BIT];
      cfg_q.cmd_en  <= wdata[CMD_EN_BIT];
      cfg_q.level   <= wdata[LEVEL_BIT];
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/cmdcnt_counters.sv
module cmdcnt_counters #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic             evt_arms,
  input  logic             ack_wr,
  input  logic [CNT_W-1:0] ack_proc,
  input  logic             ack_active,
  output logic [CNT_W-1:0] done_cnt,
  output logic [CNT_W-1:0] proc_cnt,
  output logic             active
);
  logic [CNT_W-1:0] done_q, proc_q;
  logic             active_q;

  // Hardware counting has priority of effect: a same-cycle acknowledge
  // never blocks the increment, and an armed event overrides the flag.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q   <= '0;
      proc_q   <= '0;
      active_q <= 1'b0;
    end else begin
      if (ack_wr) begin
        proc_q   <= ack_proc;
        active_q <= ack_active;
      end
      if (evt_valid) begin
        done_q <= done_q + 1'b1;
        if (evt_arms) active_q <= 1'b1;
      end
    end
  end

  assign done_cnt = done_q;
  assign proc_cnt = proc_q;
  assign active   = active_q;
endmodule

// File: rtl/cmdcnt_irq_gen.sv
module cmdcnt_irq_gen #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_mode,
  input  logic             any_en,
  input  logic             active,
  input  logic [CNT_W-1:0] done_cnt,
  input  logic [CNT_W-1:0] proc_cnt,
  input  logic             evt_fire,
  output logic             irq
);
  logic [CNT_W-1:0] pending;
  logic             pulse_q;

  // Modulo subtraction: natural wrap of the CNT_W-bit difference.
  assign pending = done_cnt - proc_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= evt_fire;
  end

  always_comb begin
    if (level_mode) irq = active | (any_en & (|pending));
    else            irq = pulse_q;
  end
endmodule

// File: rtl/cmdcnt_status.sv
module cmdcnt_status
  import cmdcnt_pkg::*;
#(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic              evt_list,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam logic ADDR_CFG = 1'b0;
  localparam logic ADDR_CNT = 1'b1;

  cfg_t             cfg;
  logic [CNT_W-1:0] done_q, proc_q;
  logic             active_q;
  logic             evt_arms;
  logic             cfg_level, cfg_list_en, cfg_cmd_en;

  assign cfg_level   = cfg.level;
  assign cfg_list_en = cfg.list_en;
  assign cfg_cmd_en  = cfg.cmd_en;
  assign evt_arms    = evt_list ? cfg_list_en : cfg_cmd_en;

  cmdcnt_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr && (reg_addr == ADDR_CFG)),
    .wdata (reg_wdata),
    .cfg   (cfg)
  );

  cmdcnt_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .evt_arms   (evt_arms),
    .ack_wr     (reg_wr && (reg_addr == ADDR_CNT)),
    .ack_proc   (reg_wdata[PROC_LSB +: CNT_W]),
    .ack_active (reg_wdata[ACTIVE_BIT]),
    .done_cnt   (done_q),
    .proc_cnt   (proc_q),
    .active     (active_q)
  );

  cmdcnt_irq_gen #(.CNT_W(CNT_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_mode (cfg_level),
    .any_en     (cfg_list_en | cfg_cmd_en),
    .active     (active_q),
    .done_cnt   (done_q),
    .proc_cnt   (proc_q),
    .evt_fire   (evt_valid & evt_arms),
    .irq        (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CNT) begin
      reg_rdata[DONE_LSB +: CNT_W] = done_q;
      reg_rdata[ACTIVE_BIT]        = active_q;
      reg_rdata[PROC_LSB +: CNT_W] = proc_q;
    end else begin
      reg_rdata[LIST_EN_BIT] = cfg_list_en;
      reg_rdata[CMD_EN_BIT]  = cfg_cmd_en;
      reg_rdata[LEVEL_BIT]   = cfg_level;
    end
  end
endmodule

// File: rtl/cmdcnt_status_chk.sv
module cmdcnt_status_chk #(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic              evt_list,
  input logic              reg_wr,
  input logic              reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq,
  input logic [CNT_W-1:0]  done_cnt,
  input logic [CNT_W-1:0]  proc_cnt,
  input logic              active,
  input logic              cfg_level,
  input logic              cfg_list_en,
  input logic              cfg_cmd_en
);
  logic armed;
  assign armed = evt_valid && (evt_list ? cfg_list_en : cfg_cmd_en);

  // R4
  a_r4_done_step: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> done_cnt == CNT_W'($past(done_cnt) + 1'b1));
  // R4, R5: software cannot move the done count
  a_r4_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> $stable(done_cnt));
  // R5
  a_r5_ack_proc: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr) |=> proc_cnt == $past(reg_wdata[16 +: CNT_W]));
  // R6
  a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> active);
  // R7
  a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !armed && !(reg_wr && reg_addr && reg_wdata[8])) |=> !active);
  // R8
  a_r8_level_active: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_level && active) |-> irq);
  // R9
  a_r9_pulse_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_level && !$past(evt_valid)) |-> !irq);
endmodule

bind cmdcnt_status cmdcnt_status_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_valid   (evt_valid),
  .evt_list    (evt_list),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .irq         (irq),
  .done_cnt    (done_q),
  .proc_cnt    (proc_q),
  .active      (active_q),
  .cfg_level   (cfg_level),
  .cfg_list_en (cfg_list_en),
  .cfg_cmd_en  (cfg_cmd_en)
);

// File: tb/cmdcnt_status_test.sv
module cmdcnt_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0, evt_list = 1'b0;
  logic        reg_wr = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  always #10 clk = ~clk; // 50 MHz

  cmdcnt_status uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_list(evt_list),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // Behavioural reference model
  int m_done = 0, m_proc = 0;
  bit m_act = 0, m_lien = 0, m_cen = 0, m_lvl = 0, m_pulse = 0;
  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit done_flag = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_done = 0; m_proc = 0; m_act = 0;
      m_lien = 0; m_cen = 0; m_lvl = 0; m_pulse = 0;
    end else begin
      bit en;
      en = evt_valid && (evt_list ? m_lien : m_cen);
      m_pulse = en;
      if (reg_wr && !reg_addr) begin
        m_lien = reg_wdata[31]; m_cen = reg_wdata[29]; m_lvl = reg_wdata[28];
      end
      if (reg_wr && reg_addr) begin
        m_proc = int'(reg_wdata[21:16]); m_act = reg_wdata[8];
      end
      if (evt_valid) m_done = (m_done + 1) % 64;
      if (en) m_act = 1;
    end
  end

  function automatic logic [31:0] exp_rdata();
    logic [31:0] v = '0;
    if (reg_addr) begin
      v[5:0] = 6'(m_done); v[8] = m_act; v[21:16] = 6'(m_proc);
    end else begin
      v[31] = m_lien; v[29] = m_cen; v[28] = m_lvl;
    end
    return v;
  endfunction

  function automatic logic exp_irq();
    int pend = (m_done - m_proc + 64) % 64;
    if (m_lvl) return m_act || (pend != 0 && (m_lien || m_cen));
    return m_pulse;
  endfunction

  task automatic compare();
    logic [31:0] er = exp_rdata();
    logic        ei = exp_irq();
    n_cmp++;
    if (reg_rdata !== er) begin
      n_bad++;
      $display("FAIL %s rdata addr=%0d actual=%h expected=%h", cur_req, reg_addr, reg_rdata, er);
    end
    n_cmp++;
    if (irq !== ei) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, ei);
    end
  endtask

  // One cycle: compare what the previous edge produced, then drive.
  task automatic cyc(input bit ev, input bit lst, input bit wr,
                     input bit adr, input logic [31:0] wd);
    @(negedge clk);
    compare();
    evt_valid = ev; evt_list = lst; reg_wr = wr; reg_addr = adr; reg_wdata = wd;
  endtask

  task automatic idle(input bit adr);
    cyc(0, 0, 0, adr, 32'h0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    int cyc_n = 0;
    while (!done_flag) begin
      @(posedge clk);
      cyc_n++;
      if (cyc_n > 100000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  initial begin
    // R1: reset state on both words
    cur_req = "R1";
    repeat (3) idle(1);
    idle(0);
    @(negedge clk); rst_n = 1'b1;
    idle(1); idle(0);

    // R3: config write with junk bits, level mode, nothing enabled
    cur_req = "R3";
    cyc(0, 0, 1, 0, 32'h5FFF_FFFF & ~32'h2000_0000); // bit28 set, 29/31 clear
    idle(0); idle(1);

    // R7: events with all enables off count but do not set the flag
    cur_req = "R7";
    for (int i = 0; i < 3; i++) cyc(1, i[0], 0, 1, 32'h0);
    idle(1); idle(1);

    // R7: only command-done enabled; list events must not arm
    cur_req = "R7";
    cyc(0, 0, 1, 0, 32'h3000_0000);
    cyc(1, 1, 0, 1, 32'h0);
    idle(1);
    cyc(1, 0, 0, 1, 32'h0);
    idle(1);

    // R5: acknowledge with junk in the done field
    cur_req = "R5";
    cyc(0, 0, 1, 1, 32'h0005_003F);
    idle(1); idle(1);

    // R2: counter word layout readback
    cur_req = "R2";
    idle(1); idle(0); idle(1);

    // R4: wrap past 63 with both classes enabled
    cur_req = "R4";
    cyc(0, 0, 1, 0, 32'hB000_0000);
    for (int i = 0; i < 70; i++) cyc(1, i[1], 0, 1, 32'h0);
    idle(1);

    // R8: stale acknowledge keeps irq up through the gap
    cur_req = "R8";
    cyc(0, 0, 1, 1, 32'h0001_0000);
    idle(1); idle(1);
    // matching acknowledge drops irq
    cyc(0, 0, 1, 1, {10'h0, 6'(m_done), 16'h0});
    idle(1); idle(1);

    // R6: event on the same cycle as an acknowledge clearing the flag
    cur_req = "R6";
    cyc(1, 0, 1, 1, {10'h0, 6'(m_done), 16'h0});
    idle(1);
    cyc(0, 0, 1, 1, {10'h0, 6'(m_done), 16'h0});
    cyc(1, 1, 1, 1, 32'h0000_003F); // proc=0, done-field junk, flag cleared
    idle(1); idle(1);

    // R9: pulse mode, mixed enabled and disabled events
    cur_req = "R9";
    cyc(0, 0, 1, 0, 32'h2000_0000); // cmd-done only, pulse mode
    cyc(1, 0, 0, 1, 32'h0);
    idle(1); idle(1);
    cyc(1, 1, 0, 1, 32'h0);
    idle(1);
    cyc(1, 0, 0, 1, 32'h0);
    cyc(1, 0, 0, 1, 32'h0);
    idle(1); idle(1);

    // R10: a read right after a write sees the new value
    cur_req = "R10";
    cyc(0, 0, 1, 0, 32'h9000_0000);
    idle(0); idle(1);

    // R1: reset mid-activity returns to zero
    cur_req = "R1";
    cyc(1, 0, 0, 1, 32'h0);
    @(negedge clk); compare(); rst_n = 1'b0; evt_valid = 0;
    idle(1); idle(1);
    @(negedge clk); compare(); rst_n = 1'b1;
    idle(0); idle(1);

    done_flag = 1;
    summary();
  end
endmodule